// File: doc/BRIEF.md
# DMA Interrupt Status Controller

This block holds the interrupt status and DMA control registers of a network controller. Eight event sources from the transmit and receive paths land in a sticky status register. Software acknowledges an event by writing 1 to its bit. One interrupt output merges the pending bits. Some bits are qualified by enables in the control register, and the error bits always reach the output.

Three of the errors are fatal: a memory error, a transmit abort and a receive overflow. When one of them occurs, the block turns both DMA enables off on the same edge. It keeps them off until software has cleared every pending fatal bit. The receive threshold event does not come from outside. The block raises it itself whenever receive is enabled and the receive FIFO entry count differs from the depth programmed in the control register.

A read of the status register also returns live copies of the receive and transmit ring read pointers and of the head message sequence number. Access goes through a single-cycle port with an address, a write strobe, write data and combinational read data. Word address 0 is the status register and word address 1 is the control register.

Top module: `dic_top`

## Requirements
- R1: After a synchronous active-low reset, the status word reads 0, the control word reads 0, and irq, tx_dma_en and rx_dma_en are 0.
- R2: An event input bit that is high at a rising edge sets the matching status bit. The bit stays set in later cycles until it is cleared. Status bit positions: 0 tx ring empty, 1 tx packet sent, 2 link failure, 3 memory error, 4 tx abort, 5 rx threshold, 6 rx underflow, 7 rx overflow.
- R3: A write to address 0 clears each status bit whose write-data bit in 7:0 is 1. Bits written with 0 keep their value.
- R4: If an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bits 3, 4 and 7 are fatal. A fatal event clears control bits 1 (tx DMA) and 15 (rx DMA) on the edge where it is captured. While any fatal bit is pending, writes cannot set those two bits.
- R6: Rx underflow (bit 6) is an error. It drives irq whatever the enables are, but it does not stop DMA.
- R7: irq is high when any of status bits 1, 2, 3, 4, 6 or 7 is pending. It is also high when bit 0 is pending with control bit 0 set, or when bit 5 is pending with control bit 9 set.
- R8: Status bit 5 is set at every edge where control bit 15 is 1 and rx_fifo_cnt differs from control bits 8:4. Event input bit 5 has no effect.
- R9: A status read returns status in 7:0, rx_rd_ptr in 12:8, zeros in 15:13, tx_rd_ptr in 24:16, head_seq in 29:25 and zeros in 31:30.
- R10: The control register keeps only bits 0, 1, 4-8, 9, 12-14 and 15 of a write, so a write of 0x0000FFFF reads back 0x0000F3F3. tx_dma_en is bit 1, rx_dma_en is bit 15 and rx_data_ofs is bits 14:12.
- R11: Reads of any address other than 0 and 1 return 0. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Word address of the register access |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| evt_in | input | 8 | Event pulses by status bit position (bit 5 unused) |
| rx_fifo_cnt | input | 5 | Current receive FIFO entry count |
| rx_rd_ptr | input | 5 | Receive ring read pointer, live |
| tx_rd_ptr | input | 9 | Transmit ring read pointer, live |
| head_seq | input | 5 | Sequence number of the head receive message |
| irq | output | 1 | Merged interrupt request |
| tx_dma_en | output | 1 | Transmit DMA enable |
| rx_dma_en | output | 1 | Receive DMA enable |
| rx_data_ofs | output | 3 | Starting byte offset of receive packet data |

## Verification
Two things can fall on the same edge: an event setting a status bit and a software write-1 clearing it. The bench drives a link-failure pulse in the very cycle that it writes 1 to that bit. It expects the bit to read back as set, and a later lone clear to take it to 0. A second collision is a fatal event against a control write that sets the DMA enables. The bench writes the enables while a fatal bit is still pending and requires both enables to stay low until that bit is cleared.

// File: rtl/dic_pkg.sv
// Shared constants of the DMA interrupt status controller: widths,
// status bit positions, class masks and control field positions.
package dic_pkg;
    localparam int DATA_W = 32;
    localparam int EV_N   = 8;
    localparam int CNT_W  = 5;
    localparam int RXP_W  = 5;
    localparam int TXP_W  = 9;
    localparam int SEQ_W  = 5;
    localparam int OFS_W  = 3;

    // status bit positions
    localparam int ST_TX_EMPTY = 0;
    localparam int ST_TX_SENT  = 1;
    localparam int ST_LINK     = 2;
    localparam int ST_MEM_ERR  = 3;
    localparam int ST_TX_ABORT = 4;
    localparam int ST_RX_THR   = 5;
    localparam int ST_RX_UNDER = 6;
    localparam int ST_RX_OVER  = 7;

    localparam logic [EV_N-1:0] FATAL_MASK =
        (EV_N'(1) << ST_MEM_ERR) | (EV_N'(1) << ST_TX_ABORT) | (EV_N'(1) << ST_RX_OVER);
    localparam logic [EV_N-1:0] ERR_MASK = FATAL_MASK | (EV_N'(1) << ST_RX_UNDER);
    localparam logic [EV_N-1:0] UNCOND_MASK =
        ERR_MASK | (EV_N'(1) << ST_TX_SENT) | (EV_N'(1) << ST_LINK);

    // control field positions
    localparam int C_TXE_IRQ   = 0;
    localparam int C_TX_DMA    = 1;
    localparam int C_DEPTH_LSB = 4;
    localparam int C_RX_IRQ    = 9;
    localparam int C_OFS_LSB   = 12;
    localparam int C_RX_DMA    = 15;

    localparam logic [DATA_W-1:0] CTRL_MASK =
        (DATA_W'(1) << C_TXE_IRQ) | (DATA_W'(1) << C_TX_DMA) |
        (DATA_W'((1 << CNT_W) - 1) << C_DEPTH_LSB) | (DATA_W'(1) << C_RX_IRQ) |
        (DATA_W'((1 << OFS_W) - 1) << C_OFS_LSB) | (DATA_W'(1) << C_RX_DMA);

    // read word field positions
    localparam int RD_RXP_LSB = 8;
    localparam int RD_TXP_LSB = 16;
    localparam int RD_SEQ_LSB = RD_TXP_LSB + TXP_W;

    // word addresses
    localparam int ADDR_STAT = 0;
    localparam int ADDR_CTRL = 1;
endpackage

// File: rtl/dic_status_reg.sv
// Sticky status register with write-1 clear and a built-in receive
// threshold comparator. Assumes clr_vec is nonzero only during a write
// to the status address. When a set and a clear meet on a bit, the set wins.
module dic_status_reg
    import dic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_N-1:0]  evt_in,
    input  logic [EV_N-1:0]  clr_vec,
    input  logic             rx_en,
    input  logic [CNT_W-1:0] depth,
    input  logic [CNT_W-1:0] fifo_cnt,
    output logic [EV_N-1:0]  status_q,
    output logic             fatal_now
);
    localparam logic [EV_N-1:0] THR_BIT = EV_N'(1) << ST_RX_THR;

    logic             thr_hit;
    logic [EV_N-1:0]  set_vec;
    logic [EV_N-1:0]  status_d;

    // threshold event: receive enabled and count differs from programmed depth
    always_comb thr_hit = rx_en && (fifo_cnt != depth);

    // assemble set requests; the threshold bit comes only from the comparator
    always_comb set_vec = (evt_in & ~THR_BIT) | (thr_hit ? THR_BIT : '0);

    // next status: clear first, then set so that a set wins a collision
    always_comb status_d = (status_q & ~clr_vec) | set_vec;

    // fatal condition seen now or still pending
    always_comb fatal_now = |((status_q | set_vec) & FATAL_MASK);

    // status register update
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(clr_vec) & $past(status_q) & ~status_q) == '0));
    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0));
    // R8
    threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && (fifo_cnt != depth)) |=> status_q[ST_RX_THR]);
endmodule

// File: rtl/dic_ctrl_reg.sv
// DMA control register. It keeps only the defined fields of a write, and a
// fatal condition forces the transmit and receive DMA enables low. Assumes
// fatal_now covers fatal events captured this cycle as well as pending ones.
module dic_ctrl_reg
    import dic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fatal_now,
    output logic [DATA_W-1:0] ctrl_q
);
    logic [DATA_W-1:0] ctrl_d;

    // next control value: masked write, then fatal override of the enables
    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) ctrl_d = wr_data & CTRL_MASK;
        if (fatal_now) begin
            ctrl_d[C_TX_DMA] = 1'b0;
            ctrl_d[C_RX_DMA] = 1'b0;
        end
    end

    // control register update
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // R5
    fatal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_now |=> (!ctrl_q[C_TX_DMA] && !ctrl_q[C_RX_DMA]));
    // R10
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_q & ~CTRL_MASK) == '0));
endmodule

// File: rtl/dic_irq_merge.sv
// Merges pending status bits into one interrupt line. Error, sent and link
// bits are unconditional; tx-empty and rx-threshold need their enables.
module dic_irq_merge
    import dic_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_N-1:0] status_q,
    input  logic            txe_irq_en,
    input  logic            rx_irq_en,
    output logic            irq
);
    // combine unconditional and enabled sources
    always_comb irq = (|(status_q & UNCOND_MASK))
                    | (status_q[ST_TX_EMPTY] & txe_irq_en)
                    | (status_q[ST_RX_THR]   & rx_irq_en);

    // R6
    error_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & ERR_MASK)) |-> irq);
    // R7
    gated_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe_irq_en && !rx_irq_en && ((status_q & UNCOND_MASK) == '0)) |-> !irq);
endmodule

// File: rtl/dic_read_mux.sv
// Read data selection. The status word carries live pointer and sequence
// aliases; unmapped addresses read zero. Assumes the fields fit in DATA_W.
module dic_read_mux
    import dic_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [EV_N-1:0]   status_q,
    input  logic [DATA_W-1:0] ctrl_q,
    input  logic [RXP_W-1:0]  rx_rd_ptr,
    input  logic [TXP_W-1:0]  tx_rd_ptr,
    input  logic [SEQ_W-1:0]  head_seq,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] stat_word;

    // build the composite status word
    always_comb begin
        stat_word = '0;
        stat_word[EV_N-1:0] = status_q;
        stat_word[RD_RXP_LSB +: RXP_W] = rx_rd_ptr;
        stat_word[RD_TXP_LSB +: TXP_W] = tx_rd_ptr;
        stat_word[RD_SEQ_LSB +: SEQ_W] = head_seq;
    end

    // select by address
    always_comb begin
        if (addr == ADDR_W'(ADDR_STAT))      rdata = stat_word;
        else if (addr == ADDR_W'(ADDR_CTRL)) rdata = ctrl_q;
        else                                 rdata = '0;
    end
endmodule

// File: rtl/dic_top.sv
// DMA interrupt status controller top. It decodes register writes and wires
// the status register, the control register, the interrupt merge and the read
// mux. Assumes single-cycle write strobes and combinational reads.
module dic_top
    import dic_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EV_N-1:0]   evt_in,
    input  logic [CNT_W-1:0]  rx_fifo_cnt,
    input  logic [RXP_W-1:0]  rx_rd_ptr,
    input  logic [TXP_W-1:0]  tx_rd_ptr,
    input  logic [SEQ_W-1:0]  head_seq,
    output logic              irq,
    output logic              tx_dma_en,
    output logic              rx_dma_en,
    output logic [OFS_W-1:0]  rx_data_ofs
);
    logic              wr_stat;
    logic              wr_ctrl;
    logic [EV_N-1:0]   clr_vec;
    logic [EV_N-1:0]   status_q;
    logic [DATA_W-1:0] ctrl_q;
    logic              fatal_now;

    // write decode per register
    always_comb begin
        wr_stat = reg_wr_en && (reg_addr == ADDR_W'(ADDR_STAT));
        wr_ctrl = reg_wr_en && (reg_addr == ADDR_W'(ADDR_CTRL));
        clr_vec = wr_stat ? reg_wdata[EV_N-1:0] : '0;
    end

    dic_status_reg u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_in),
        .clr_vec   (clr_vec),
        .rx_en     (ctrl_q[C_RX_DMA]),
        .depth     (ctrl_q[C_DEPTH_LSB +: CNT_W]),
        .fifo_cnt  (rx_fifo_cnt),
        .status_q  (status_q),
        .fatal_now (fatal_now)
    );

    dic_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ctrl),
        .wr_data   (reg_wdata),
        .fatal_now (fatal_now),
        .ctrl_q    (ctrl_q)
    );

    dic_irq_merge u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .status_q   (status_q),
        .txe_irq_en (ctrl_q[C_TXE_IRQ]),
        .rx_irq_en  (ctrl_q[C_RX_IRQ]),
        .irq        (irq)
    );

    dic_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr      (reg_addr),
        .status_q  (status_q),
        .ctrl_q    (ctrl_q),
        .rx_rd_ptr (rx_rd_ptr),
        .tx_rd_ptr (tx_rd_ptr),
        .head_seq  (head_seq),
        .rdata     (reg_rdata)
    );

    // drive the control field outputs
    always_comb begin
        tx_dma_en   = ctrl_q[C_TX_DMA];
        rx_dma_en   = ctrl_q[C_RX_DMA];
        rx_data_ofs = ctrl_q[C_OFS_LSB +: OFS_W];
    end
endmodule

// File: tb/test_dic_top.sv
// Directed bench for dic_top: one task per scenario, each checking its results.
module test_dic_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_in;
    logic [4:0]  rx_fifo_cnt;
    logic [4:0]  rx_rd_ptr;
    logic [8:0]  tx_rd_ptr;
    logic [4:0]  head_seq;
    logic        irq;
    logic        tx_dma_en;
    logic        rx_dma_en;
    logic [2:0]  rx_data_ofs;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dic_top i_dic_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
        .rx_fifo_cnt(rx_fifo_cnt), .rx_rd_ptr(rx_rd_ptr), .tx_rd_ptr(tx_rd_ptr),
        .head_seq(head_seq), .irq(irq), .tx_dma_en(tx_dma_en),
        .rx_dma_en(rx_dma_en), .rx_data_ofs(rx_data_ofs)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // one write cycle; returns at the following falling edge
    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse_evt(input logic [7:0] m);
        evt_in = m;
        @(posedge clk); @(negedge clk);
        evt_in = '0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        read_reg(0, v); check("R1 status after reset", v, 0);
        read_reg(1, v); check("R1 ctrl after reset", v, 0);
        check("R1 irq after reset", {31'b0, irq}, 0);
        check("R1 dma enables after reset", {30'b0, tx_dma_en, rx_dma_en}, 0);
    endtask

    task automatic t_sticky_w1c();
        logic [31:0] v;
        pulse_evt(8'h02);
        @(negedge clk);
        read_reg(0, v); check("R2 sent bit sticky", v, 32'h02);
        check("R7 sent bit unconditional irq", {31'b0, irq}, 1);
        do_write(0, 32'h0000_0000);
        read_reg(0, v); check("R3 write 0 keeps bit", v, 32'h02);
        do_write(0, 32'h0000_0002);
        read_reg(0, v); check("R3 write 1 clears bit", v, 0);
        check("R7 irq drops after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_txe_gating();
        logic [31:0] v;
        pulse_evt(8'h01);
        read_reg(0, v); check("R2 tx empty set", v, 32'h01);
        check("R7 tx empty masked", {31'b0, irq}, 0);
        do_write(1, 32'h0000_0001);
        check("R7 tx empty enabled", {31'b0, irq}, 1);
        do_write(0, 32'h01);
        do_write(1, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        pulse_evt(8'h04);
        evt_in = 8'h04;
        do_write(0, 32'h04);
        evt_in = '0;
        read_reg(0, v); check("R4 set wins over clear", v, 32'h04);
        do_write(0, 32'h04);
        read_reg(0, v); check("R3 lone clear after collision", v, 0);
    endtask

    task automatic t_fatal();
        logic [31:0] v;
        rx_fifo_cnt = 0;
        do_write(1, 32'h0000_8002);
        check("R10 enables on", {30'b0, tx_dma_en, rx_dma_en}, 32'h3);
        pulse_evt(8'h08);
        check("R5 fatal stops dma", {30'b0, tx_dma_en, rx_dma_en}, 0);
        check("R7 fatal irq", {31'b0, irq}, 1);
        do_write(1, 32'h0000_8002);
        check("R5 enable blocked while pending", {30'b0, tx_dma_en, rx_dma_en}, 0);
        do_write(0, 32'h08);
        do_write(1, 32'h0000_8002);
        check("R5 enable after clear", {30'b0, tx_dma_en, rx_dma_en}, 32'h3);
        pulse_evt(8'h80);
        check("R5 overflow stops dma", {30'b0, tx_dma_en, rx_dma_en}, 0);
        do_write(0, 32'h80);
        read_reg(0, v); check("R5 status cleared", v, 0);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        do_write(1, 32'h0000_8002);
        pulse_evt(8'h40);
        check("R6 underflow irq", {31'b0, irq}, 1);
        check("R6 underflow keeps dma", {30'b0, tx_dma_en, rx_dma_en}, 32'h3);
        do_write(1, 32'h0);
        do_write(0, 32'h40);
        read_reg(0, v); check("R6 underflow cleared", v, 0);
    endtask

    task automatic t_threshold();
        logic [31:0] v;
        pulse_evt(8'h20);
        read_reg(0, v); check("R8 event bit 5 ignored", v, 0);
        rx_fifo_cnt = 5'd3;
        do_write(1, 32'h0000_8030);
        @(negedge clk);
        read_reg(0, v); check("R8 equal count no event", v, 0);
        rx_fifo_cnt = 5'd4;
        @(negedge clk);
        read_reg(0, v); check("R8 unequal count event", v, 32'h20);
        check("R7 threshold masked", {31'b0, irq}, 0);
        do_write(1, 32'h0000_8230);
        check("R7 threshold enabled", {31'b0, irq}, 1);
        rx_fifo_cnt = 5'd3;
        do_write(1, 32'h0);
        do_write(0, 32'hFF);
        read_reg(0, v); check("R8 threshold cleared", v, 0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        rx_rd_ptr = 5'h15; tx_rd_ptr = 9'h1A5; head_seq = 5'h0B;
        pulse_evt(8'h02);
        read_reg(0, v);
        check("R9 status word layout", v,
              {2'b00, 5'h0B, 9'h1A5, 3'b000, 5'h15, 8'h02});
        rx_rd_ptr = 0; tx_rd_ptr = 0; head_seq = 0;
        do_write(0, 32'h02);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        do_write(1, 32'h0000_FFFF);
        read_reg(1, v); check("R10 ctrl mask", v, 32'h0000_F3F3);
        check("R10 data offset", {29'b0, rx_data_ofs}, 32'h7);
        do_write(1, 32'h0000_5000);
        check("R10 data offset 5", {29'b0, rx_data_ofs}, 32'h5);
        do_write(1, 32'h0);
        do_write(0, 32'hFF);
        read_reg(0, v); check("R10 status clean", v, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        pulse_evt(8'h04);
        do_write(4'd5, 32'hFFFF_FFFF);
        read_reg(4'd5, v); check("R11 unmapped reads zero", v, 0);
        read_reg(1, v); check("R11 ctrl untouched", v, 0);
        read_reg(0, v); check("R11 status untouched", v, 32'h04);
        do_write(0, 32'h04);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wdata = '0;
        evt_in = '0; rx_fifo_cnt = '0; rx_rd_ptr = '0; tx_rd_ptr = '0; head_seq = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_sticky_w1c();
        t_txe_gating();
        t_collision();
        t_fatal();
        t_underflow();
        t_threshold();
        t_layout();
        t_ctrl_mask();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule